// File: doc/BRIEF.md
# Inertial Sensor Bring-Up Sequencer

This block is the host-side controller that starts an inertial sensor after a reset in a way that leaves the sensor's internal fault diagnostics armed. It first pulses the sensor's reset line low. It then waits until the serial bus may be used and writes the output filter choice. It waits again until the sensor's measurement data is valid. After that it reads every status register twice. The first pass clears the faults latched during the sensor's own startup. The second pass confirms that each register now reports normal operation.

The block does not shift bits itself. It hands whole 32-bit request words to an SPI frame engine, which also fills in the CRC byte. For each request, the engine returns the 32-bit word that came back on the data-out line while that request was being sent. Because the protocol is off-frame, each returned word answers the previous request. The sequencer lines them up by frame index.

Time is counted in pulses of a one-millisecond tick input. If a check fails, the whole sequence starts again from the reset pulse, up to a fixed number of attempts. The `done` output marks success. The `fail` output marks that the attempt limit was reached.

Top module: `ssq_startup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sens_rst_n` is low and `cmd_valid`, `done`, `fail` and `retry` are all 0. `sens_rst_n` stays low for at least RST_LOW_MS (default 2) tick pulses of each attempt and then goes high.
- R2: No request is offered (`cmd_valid`) until SPI_WAIT_MS (default 20) tick pulses have been counted since `sens_rst_n` went high.
- R3: Request words use this layout: bit 31 is the write flag, bits 30:26 are the register address, bits 25:24 are 0, bits 23:8 are data, and bits 7:0 are 0. The first request of an attempt writes address 1Fh with the two-bit filter field at data bits 13:12. The field is 10b when `filt_10hz`=0 (word FC200000h) and 01b when `filt_10hz`=1 (word FC100000h).
- R4: The second request of an attempt is not offered until VALID_60_MS (620) tick pulses (60 Hz filter) or VALID_10_MS (750) tick pulses (10 Hz filter) have been counted since `sens_rst_n` went high.
- R5: Requests 1 to 5 and requests 6 to 10 each read addresses 09h, 0Ah, 0Fh, 1Bh and 1Fh in that order. Request 11 is one extra read of 1Fh. A read word is {1'b0, addr, 26'b0}.
- R6: Responses that answer request 0 or any request of the first read pass are ignored. This includes the undefined first response of each attempt and any error status or clear loop bit they carry.
- R7: Each response answering a request of the second read pass must echo that request's write flag and address in bits 31:26 and must carry return status 01b in bits 25:24.
- R8: The response answering the second-pass read of 1Bh must have data bit LOOP_OK_BIT (default 1, word bit 9) set.
- R9: A failed check that is not the last allowed attempt gives a one-cycle `retry` pulse and restarts the sequence with a new reset pulse.
- R10: After MAX_TRIES (3) consecutive failed attempts, `fail` rises without a `retry` pulse and stays high. No further requests are offered.
- R11: When the response to request 11 passes, `done` rises and stays high. No further requests are offered, and `done` and `fail` are never high together.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_word` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| filt_10hz | input | 1 | Filter choice: 0 selects 60 Hz, 1 selects 10 Hz; sampled when the filter write is about to be issued |
| cmd_valid | output | 1 | Request word offered to the frame engine |
| cmd_ready | input | 1 | Frame engine takes the offered word |
| cmd_word | output | 32 | Request word (CRC byte left 0 for the engine) |
| rsp_valid | input | 1 | One-cycle pulse: the frame carrying the last request has finished |
| rsp_word | input | 32 | Word received during that frame |
| sens_rst_n | output | 1 | Active-low reset line to the sensor |
| done | output | 1 | Bring-up finished successfully |
| fail | output | 1 | Attempt limit reached |
| retry | output | 1 | One-cycle pulse when a failed attempt is restarted |

## Verification
The hardest situation to reach is a fault that appears only in the second read pass and only on some attempts. Here the block must restart, line up the delayed responses of the new attempt from scratch, and still finish, or give up on exactly the third failure. The bench's frame-engine model builds each response from the previous request. It then corrupts one chosen response index in either the first attempt only or in every attempt. The corruption is a bad return status, a cleared loop bit, or a wrong echoed address. The same corruptions placed in the first read pass must leave the outcome unchanged.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      S_RST_LO,
      S_BOOT,
      S_ISSUE,
      S_WAIT,
      S_SETTLE,
      S_DONE,
      S_FAIL
   } ssq_state_e;

   typedef struct packed {
      logic        wr;
      logic [4:0]  addr;
      logic [1:0]  rs;
      logic [15:0] data;
      logic [7:0]  crc;
   } ssq_frame_t;

   localparam int unsigned NUM_STAT   = 5;
   localparam int unsigned NUM_FRAMES = 2 * NUM_STAT + 2;

   localparam logic [4:0] ADDR_SUMMARY = 5'h1F;
   localparam logic [4:0] ADDR_COMMON  = 5'h1B;
   localparam logic [1:0] RS_NORMAL    = 2'b01;

endpackage

// File: rtl/ssq_ms_timer.sv
module ssq_ms_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick && (cnt != CNT_TOP)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ssq_frame_gen.sv
module ssq_frame_gen
   import ssq_pkg::*;
#(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned FLT_LSB = 12
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             filt_10hz,
   output logic [31:0]      req_word,
   output logic [5:0]       prev_op,
   output logic             prev_checked,
   output logic             prev_common
);

   localparam logic [IDX_W-1:0] PASS_LEN  = IDX_W'(NUM_STAT);
   localparam logic [IDX_W-1:0] PASS2_LO  = IDX_W'(NUM_STAT + 1);
   localparam logic [IDX_W-1:0] PASS2_HI  = IDX_W'(2 * NUM_STAT);

   generate
      if (FLT_LSB > 14) begin : g_bad_flt
         $error("filter field does not fit in the data field");
      end
      if ((1 << IDX_W) < NUM_FRAMES) begin : g_bad_idx
         $error("frame index too narrow");
      end
   endgenerate

   function automatic logic [4:0] status_addr(input logic [IDX_W-1:0] slot);
      logic [4:0] a;
      if (slot == IDX_W'(0))      a = 5'h09;
      else if (slot == IDX_W'(1)) a = 5'h0A;
      else if (slot == IDX_W'(2)) a = 5'h0F;
      else if (slot == IDX_W'(3)) a = ADDR_COMMON;
      else                        a = ADDR_SUMMARY;
      return a;
   endfunction

   function automatic ssq_frame_t build(input logic [IDX_W-1:0] i, input logic f10);
      ssq_frame_t       fr;
      logic [IDX_W-1:0] slot;
      fr   = '0;
      slot = '0;
      if (i == '0) begin
         fr.wr   = 1'b1;
         fr.addr = ADDR_SUMMARY;
         fr.data = (f10 ? 16'd1 : 16'd2) << FLT_LSB;
      end else if (i <= PASS2_HI) begin
         slot = i - 1'b1;
         if (slot >= PASS_LEN) slot = slot - PASS_LEN;
         fr.addr = status_addr(slot);
      end else begin
         fr.addr = ADDR_SUMMARY;
      end
      return fr;
   endfunction

   function automatic logic [5:0] op_of(input logic [IDX_W-1:0] i, input logic f10);
      ssq_frame_t fr;
      fr = build(i, f10);
      return {fr.wr, fr.addr};
   endfunction

   logic [IDX_W-1:0] pidx;

   always_comb begin
      pidx         = idx - 1'b1;
      req_word     = build(idx, filt_10hz);
      prev_op      = op_of(pidx, filt_10hz);
      prev_checked = (idx != '0) && (pidx >= PASS2_LO) && (pidx <= PASS2_HI);
      prev_common  = (prev_op[4:0] == ADDR_COMMON);
   end

endmodule

// File: rtl/ssq_rsp_check.sv
module ssq_rsp_check
   import ssq_pkg::*;
#(
   parameter int unsigned LOOP_OK_BIT = 1,
   parameter bit          CHECK_LOOP  = 1'b1
) (
   input  logic [31:0] rsp_word,
   input  logic [5:0]  exp_op,
   input  logic        checked,
   input  logic        is_common,
   output logic        bad
);

   ssq_frame_t r;
   logic       hdr_bad;
   logic       loop_bad;
   logic       unused_bits;

   assign r           = rsp_word;
   assign unused_bits = ^{r.data, r.crc};
   assign hdr_bad     = ({r.wr, r.addr} != exp_op) || (r.rs != RS_NORMAL);

   generate
      if (LOOP_OK_BIT > 15) begin : g_bad_bit
         $error("loop bit outside the data field");
      end
      if (CHECK_LOOP) begin : g_loop
         assign loop_bad = is_common && !r.data[LOOP_OK_BIT];
      end else begin : g_noloop
         assign loop_bad = is_common & 1'b0;
      end
   endgenerate

   assign bad = checked && (hdr_bad || loop_bad);

endmodule

// File: rtl/ssq_startup_seq.sv
module ssq_startup_seq
   import ssq_pkg::*;
#(
   parameter int unsigned RST_LOW_MS  = 2,
   parameter int unsigned SPI_WAIT_MS = 20,
   parameter int unsigned VALID_60_MS = 620,
   parameter int unsigned VALID_10_MS = 750,
   parameter int unsigned MAX_TRIES   = 3,
   parameter int unsigned FLT_LSB     = 12,
   parameter int unsigned LOOP_OK_BIT = 1,
   parameter bit          CHECK_LOOP  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ms_tick,
   input  logic        filt_10hz,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic [31:0] cmd_word,
   input  logic        rsp_valid,
   input  logic [31:0] rsp_word,
   output logic        sens_rst_n,
   output logic        done,
   output logic        fail,
   output logic        retry
);

   localparam int unsigned IDX_W    = $clog2(NUM_FRAMES);
   localparam int unsigned LAST_IDX = NUM_FRAMES - 1;
   localparam int unsigned MAX_V    = (VALID_10_MS > VALID_60_MS) ? VALID_10_MS : VALID_60_MS;
   localparam int unsigned MAX_MS   = (MAX_V > SPI_WAIT_MS) ? MAX_V : SPI_WAIT_MS;
   localparam int unsigned CNT_W    = $clog2(MAX_MS + 2);
   localparam int unsigned TRY_W    = $clog2(MAX_TRIES + 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("at least one attempt is required");
      end
      if (RST_LOW_MS < 1) begin : g_bad_low
         $error("reset pulse needs at least one tick");
      end
      if ((VALID_60_MS <= SPI_WAIT_MS) || (VALID_10_MS <= SPI_WAIT_MS)) begin : g_bad_valid
         $error("data-valid wait must exceed bus wait");
      end
   endgenerate

   ssq_state_e        state, st_n;
   logic [IDX_W-1:0]  idx, idx_n;
   logic [TRY_W-1:0]  tries, tries_n;
   logic              filt_q, filt_n;
   logic              retry_q, retry_n;
   logic              tmr_clr;
   logic [CNT_W-1:0]  ms_cnt;
   logic [CNT_W-1:0]  valid_ms;
   logic [5:0]        prev_op;
   logic              prev_checked;
   logic              prev_common;
   logic              rsp_bad;

   ssq_ms_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (ms_tick),
      .cnt   (ms_cnt)
   );

   ssq_frame_gen #(.IDX_W(IDX_W), .FLT_LSB(FLT_LSB)) u_gen (
      .idx          (idx),
      .filt_10hz    (filt_q),
      .req_word     (cmd_word),
      .prev_op      (prev_op),
      .prev_checked (prev_checked),
      .prev_common  (prev_common)
   );

   ssq_rsp_check #(.LOOP_OK_BIT(LOOP_OK_BIT), .CHECK_LOOP(CHECK_LOOP)) u_chk_rsp (
      .rsp_word  (rsp_word),
      .exp_op    (prev_op),
      .checked   (prev_checked),
      .is_common (prev_common),
      .bad       (rsp_bad)
   );

   assign valid_ms = filt_q ? CNT_W'(VALID_10_MS) : CNT_W'(VALID_60_MS);

   always_comb begin
      st_n    = state;
      idx_n   = idx;
      tries_n = tries;
      filt_n  = filt_q;
      retry_n = 1'b0;
      tmr_clr = 1'b0;
      case (state)
         S_RST_LO: begin
            if (ms_cnt >= CNT_W'(RST_LOW_MS)) begin
               st_n    = S_BOOT;
               tmr_clr = 1'b1;
            end
         end
         S_BOOT: begin
            if (ms_cnt >= CNT_W'(SPI_WAIT_MS)) begin
               st_n   = S_ISSUE;
               idx_n  = '0;
               filt_n = filt_10hz;
            end
         end
         S_ISSUE: begin
            if (cmd_ready) st_n = S_WAIT;
         end
         S_WAIT: begin
            if (rsp_valid) begin
               if (rsp_bad) begin
                  tmr_clr = 1'b1;
                  if (tries == TRY_W'(MAX_TRIES - 1)) begin
                     st_n = S_FAIL;
                  end else begin
                     tries_n = tries + 1'b1;
                     retry_n = 1'b1;
                     st_n    = S_RST_LO;
                  end
               end else if (idx == '0) begin
                  st_n = S_SETTLE;
               end else if (idx == IDX_W'(LAST_IDX)) begin
                  st_n = S_DONE;
               end else begin
                  idx_n = idx + 1'b1;
                  st_n  = S_ISSUE;
               end
            end
         end
         S_SETTLE: begin
            if (ms_cnt >= valid_ms) begin
               idx_n = IDX_W'(1);
               st_n  = S_ISSUE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_RST_LO;
         idx     <= '0;
         tries   <= '0;
         filt_q  <= 1'b0;
         retry_q <= 1'b0;
      end else begin
         state   <= st_n;
         idx     <= idx_n;
         tries   <= tries_n;
         filt_q  <= filt_n;
         retry_q <= retry_n;
      end
   end

   assign cmd_valid  = (state == S_ISSUE);
   assign sens_rst_n = (state != S_RST_LO);
   assign done       = (state == S_DONE);
   assign fail       = (state == S_FAIL);
   assign retry      = retry_q;

endmodule

// File: rtl/ssq_startup_chk.sv
module ssq_startup_chk #(
   parameter int unsigned SPI_WAIT_MS = 20,
   parameter int unsigned CNT_W       = 10
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ms_tick,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic [31:0] cmd_word,
   input logic        sens_rst_n,
   input logic        done,
   input logic        fail,
   input logic        retry
);

   logic [CNT_W-1:0] rel_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rel_cnt <= '0;
      else if (!sens_rst_n)                    rel_cnt <= '0;
      else if (ms_tick && (rel_cnt != '1))     rel_cnt <= rel_cnt + 1'b1;
   end

   p_no_early_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (rel_cnt >= CNT_W'(SPI_WAIT_MS)));

   p_no_cmd_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sens_rst_n |-> !cmd_valid && !done && !fail);

   p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

   p_retry_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retry |=> !retry);

   p_retry_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> !sens_rst_n);

   p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> (fail && !cmd_valid && !retry));

   p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !cmd_valid));

   p_done_fail_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

endmodule

bind ssq_startup_seq ssq_startup_chk #(
   .SPI_WAIT_MS (SPI_WAIT_MS),
   .CNT_W       (CNT_W)
) u_startup_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ms_tick    (ms_tick),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_word   (cmd_word),
   .sens_rst_n (sens_rst_n),
   .done       (done),
   .fail       (fail),
   .retry      (retry)
);

// File: tb/ssq_startup_seq_bench.sv
module ssq_startup_seq_bench;

   localparam int RST_LOW  = 2;
   localparam int BUS_WAIT = 20;
   localparam int V60      = 620;
   localparam int V10      = 750;
   localparam int NV       = 8;

   // fields: [11] filt, [10:9] fault kind (0 none,1 bad RS,2 loop bit low,3 bad echo),
   // [8:5] response index, [4] fault on every attempt, [3] expect done, [2:0] expected retries
   localparam logic [11:0] VEC [0:NV-1] = '{
      {1'b0, 2'd0, 4'd0,  1'b0, 1'b1, 3'd0},
      {1'b1, 2'd0, 4'd0,  1'b0, 1'b1, 3'd0},
      {1'b0, 2'd1, 4'd3,  1'b0, 1'b1, 3'd0},
      {1'b0, 2'd1, 4'd8,  1'b0, 1'b1, 3'd1},
      {1'b1, 2'd2, 4'd10, 1'b0, 1'b1, 3'd1},
      {1'b0, 2'd3, 4'd11, 1'b0, 1'b1, 3'd1},
      {1'b0, 2'd1, 4'd7,  1'b1, 1'b0, 3'd2},
      {1'b0, 2'd2, 4'd5,  1'b0, 1'b1, 3'd0}
   };

   localparam logic [4:0] RD_ADDR [0:4] = '{5'h09, 5'h0A, 5'h0F, 5'h1B, 5'h1F};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic        filt_10hz = 1'b0;
   logic        cmd_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_word = '0;
   logic        cmd_valid;
   logic [31:0] cmd_word;
   logic        sens_rst_n;
   logic        done;
   logic        fail;
   logic        retry;

   int          n_chk = 0;
   int          n_fail = 0;
   int          fidx = 0;
   logic [31:0] prev_w = '0;
   logic [31:0] words [0:15];
   int          tks [0:15];
   int          tk_rel = 0;
   int          tk_low = 0;
   int          low_last = 0;
   int          attempt = -1;
   int          retries = 0;
   int          hold_err = 0;
   logic        pin_q = 1'b1;
   int          f_kind = 0;
   int          f_frame = 0;
   bit          f_pers = 1'b0;
   int          div = 0;

   ssq_startup_seq u_ssq_startup_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .filt_10hz  (filt_10hz),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_word   (cmd_word),
      .rsp_valid  (rsp_valid),
      .rsp_word   (rsp_word),
      .sens_rst_n (sens_rst_n),
      .done       (done),
      .fail       (fail),
      .retry      (retry)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int k, input bit f10);
      if (k == 0) return f10 ? 32'hFC10_0000 : 32'hFC20_0000;
      if (k <= 10) return {1'b0, RD_ADDR[(k-1) % 5], 26'b0};
      return {1'b0, 5'h1F, 26'b0};
   endfunction

   // millisecond tick, changed away from the clock edges
   initial begin
      forever begin
         @(posedge clk);
         #2;
         div     = (div + 1) % 4;
         ms_tick = (div == 0);
      end
   end

   // bench-side observation of reset pin, ticks and retry pulses
   always @(negedge clk) begin
      if (!sens_rst_n) begin
         if (pin_q) begin
            attempt++;
            tk_low = 0;
         end
         tk_rel = 0;
         if (ms_tick) tk_low++;
      end else begin
         if (!pin_q) low_last = tk_low;
         if (ms_tick) tk_rel++;
      end
      pin_q = sens_rst_n;
      if (retry) retries++;
   end

   // frame engine and sensor model: each response answers the previous request
   initial begin
      forever begin
         @(negedge clk);
         if (!sens_rst_n) begin
            fidx   = 0;
            prev_w = '0;
         end else if (cmd_valid) begin
            logic [31:0] w;
            logic [31:0] r;
            logic [15:0] d;
            w = cmd_word;
            if (fidx < 16) tks[fidx] = tk_rel;
            repeat (2) begin
               @(negedge clk);
               if (!cmd_valid || (cmd_word !== w)) hold_err++;
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            if (fidx == 0) begin
               r = 32'hDEAD_BEEF;
            end else begin
               d = (prev_w[30:26] == 5'h1B) ? 16'h0002 : (16'h4C00 ^ 16'(fidx));
               r = {prev_w[31:26], 2'b01, d, 8'h5A};
            end
            if ((f_kind != 0) && (fidx == f_frame) && (f_pers || attempt == 0)) begin
               if (f_kind == 1) r[25:24] = 2'b11;
               if (f_kind == 2) r[9] = 1'b0;
               if (f_kind == 3) r[26] = ~r[26];
            end
            if (fidx < 16) words[fidx] = w;
            prev_w = w;
            fidx++;
            repeat (4) @(negedge clk);
            rsp_word  = r;
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
         end
      end
   end

   initial begin
      for (int v = 0; v < NV; v++) begin
         logic [11:0] vec;
         int          cyc;
         int          n_cv;
         int          vlim;
         bit          exp_done;
         vec       = VEC[v];
         filt_10hz = vec[11];
         f_kind    = int'(vec[10:9]);
         f_frame   = int'(vec[8:5]);
         f_pers    = vec[4];
         exp_done  = vec[3];
         vlim      = vec[11] ? V10 : V60;

         @(negedge clk);
         rst_n    = 1'b0;
         attempt  = -1;
         retries  = 0;
         hold_err = 0;
         pin_q    = 1'b1;
         repeat (3) @(negedge clk);
         if (v == 0) begin
            chk(sens_rst_n == 1'b0, "R1 reset pin low in reset", 32'(sens_rst_n), 32'd0);
            chk({cmd_valid, done, fail, retry} == 4'b0, "R1 outputs idle in reset",
                32'({cmd_valid, done, fail, retry}), 32'd0);
         end
         rst_n = 1'b1;
         @(negedge clk);
         if (v == 0) begin
            chk(sens_rst_n == 1'b0, "R1 reset pin low after release", 32'(sens_rst_n), 32'd0);
         end

         cyc = 0;
         while (!(done || fail) && cyc < 60000) begin
            @(negedge clk);
            cyc++;
         end
         chk(cyc < 60000, "R11 watchdog expired", 32'(cyc), 32'd60000);

         chk(done == exp_done, "R11 done outcome", 32'(done), 32'(exp_done));
         chk(fail == !exp_done, "R10 fail outcome", 32'(fail), 32'(!exp_done));
         chk(retries == int'(vec[2:0]), "R9 retry pulse count", 32'(retries), 32'(vec[2:0]));
         chk(low_last >= RST_LOW, "R1 reset pulse length", 32'(low_last), 32'(RST_LOW));
         chk(hold_err == 0, "R12 word held until taken", 32'(hold_err), 32'd0);
         chk(tks[0] >= BUS_WAIT && tks[0] <= BUS_WAIT + 1, "R2 bus wait before first request",
             32'(tks[0]), 32'(BUS_WAIT));
         chk(words[0] == exp_word(0, vec[11]), "R3 filter write word", words[0], exp_word(0, vec[11]));
         chk(tks[1] >= vlim && tks[1] <= vlim + 1, "R4 data-valid wait",
             32'(tks[1]), 32'(vlim));

         if (exp_done) begin
            chk(fidx == 12, "R5 frame count", 32'(fidx), 32'd12);
            for (int k = 1; k < 12; k++) begin
               chk(words[k] == exp_word(k, vec[11]), "R5 read sequence", words[k], exp_word(k, vec[11]));
            end
            if (f_kind != 0 && f_frame <= 6) begin
               chk(retries == 0, "R6 first-pass response ignored", 32'(retries), 32'd0);
            end
            if (f_kind == 2 && f_frame == 10) begin
               chk(retries == 1, "R8 loop bit low restarts", 32'(retries), 32'd1);
            end
            if ((f_kind == 1 || f_kind == 3) && f_frame >= 7) begin
               chk(retries == 1, "R7 bad status or echo restarts", 32'(retries), 32'd1);
            end
         end else begin
            chk(fidx == f_frame + 1, "R10 stop at failing frame", 32'(fidx), 32'(f_frame + 1));
            chk(attempt == 2, "R10 three attempts made", 32'(attempt), 32'd2);
         end

         n_cv = 0;
         repeat (40) begin
            @(negedge clk);
            if (cmd_valid || retry || (done != exp_done) || (fail == exp_done)) n_cv++;
         end
         chk(n_cv == 0, exp_done ? "R11 idle and sticky after done" : "R10 idle and sticky after fail",
             32'(n_cv), 32'd0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule